// File: doc/BRIEF.md
# Dual-Requester Memory Decoder with Write Protection

This block sits between two processors, a host and a coprocessor, and the memories they share. For each access it turns a 24-bit address, a read/write flag and the requester's identity into a one-hot device select, a local device address and a write-permit flag. The devices are a small control-register window, a 2 KB internal RAM, and a battery-backed RAM that can be reached linearly, through an 8 KB banked window, or, for the coprocessor only, through a packed-pixel bitmap view.

The block holds its own bank and protection registers. They are written through the same register window it decodes, by either requester. Each requester has its own window bank, its own backup-RAM write enable and its own set of per-256-byte internal-RAM write enables. A programmable region at the bottom of backup RAM needs the enable before it can be written. An access that hits no device raises no select; the surrounding read mux then returns FFh. A write that protection refuses is dropped, because the write-permit flag stays low.

Top module: `dual_bus_decoder`

## Requirements
- R1: `sel_o` is one-hot or zero, with bit 0 = register window, bit 1 = internal RAM, bit 2 = backup RAM normal view, bit 3 = backup RAM bitmap view. With `req_i` low, or with no match, `sel_o`, `dev_addr_o` and `wr_ok_o` are all zero, and the read data is then FFh outside this block.
- R2: In any bank with address bit 22 clear (00-3F, 80-BF), offsets 2200h-23FFh select the register window, with `dev_addr_o` = offset bits 8:0.
- R3: In those banks, offsets 3000h-37FFh select internal RAM for both requesters, with `dev_addr_o` = offset bits 10:0. The coprocessor (`side_i`=1) also sees internal RAM at offsets 0000h-07FFh; the host does not.
- R4: For the host, offsets 6000h-7FFFh in those banks select backup RAM normal view, with `dev_addr_o` = host bank × 2000h + offset bits 12:0. The host bank is the low 5 bits of register 024h.
- R5: For the coprocessor, the same window uses register 025h: bits 6:0 give the bank, and bit 7 picks the bitmap view (select bit 3) over the normal view (select bit 2). The address is formed as in R4.
- R6: Banks 40h-4Fh select backup RAM normal view for both requesters, with `dev_addr_o` = address bits 19:0. Banks C0h-CFh and all other unlisted banks give no select.
- R7: Banks 60h-6Fh select the bitmap view, with `dev_addr_o` = address bits 19:0, for the coprocessor only. The host gets no select there.
- R8: Bit 7 of register 026h (host) and of register 027h (coprocessor) is that requester's backup-RAM write enable. Bitmap-view writes are permitted only when the coprocessor enable is set. The other bits of these registers have no effect.
- R9: The low 4 bits N of register 028h protect the normal-view bytes with `dev_addr_o` < N×256. A write there needs the requester's enable. Writes at or above that boundary are permitted regardless.
- R10: Registers 029h (host) and 02Ah (coprocessor) each have one bit per 256-byte chunk of internal RAM. Bit k permits that requester's writes where `dev_addr_o[10:8]` = k.
- R11: Register-window writes always raise `wr_ok_o`. They update the addressed register at the clock edge, so the new value governs accesses from the next cycle on. Writes to other window offsets change nothing.
- R12: After reset every bank and protection register is zero. Internal-RAM writes and bitmap writes are therefore refused, and the host window starts at backup-RAM address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access valid this cycle |
| side_i | input | 1 | Requester: 0 host, 1 coprocessor |
| wr_i | input | 1 | 1 for a write access |
| addr_i | input | 24 | Bank (23:16) and offset (15:0) |
| wdata_i | input | 8 | Write data, used for register writes |
| sel_o | output | 4 | One-hot device select (see R1) |
| dev_addr_o | output | 20 | Address local to the selected device |
| wr_ok_o | output | 1 | Write permitted to the selected device |

## Verification
The decode itself has no state, so a wrong select or address appears on the ports in the same cycle as the access. Faults in the stored bank or protection registers are different: they only show at the ports once an access goes through the window or asks for a write. For that reason every register is written and then read back through a dependent access in the very next cycle. The protection boundaries are probed one byte either side, and each requester is tried against the other requester's enables, so that a swapped side or an off-by-one limit changes `wr_ok_o` or `dev_addr_o` at once.

// File: rtl/dual_bus_decoder_pkg.sv
package dual_bus_decoder_pkg;
  localparam int ADDR_W     = 24;
  localparam int DEV_AW     = 20;
  localparam int DATA_W     = 8;
  localparam int REG_AW     = 9;
  localparam int IRAM_AW    = 11;
  localparam int CHUNK_AW   = 8;
  localparam int CHUNK_IW   = IRAM_AW - CHUNK_AW;
  localparam int N_CHUNKS   = 1 << CHUNK_IW;
  localparam int WIN_AW     = 13;
  localparam int HBANK_W    = 5;
  localparam int CBANK_W    = 7;
  localparam int PROT_W     = 4;
  localparam int N_SEL      = 4;

  localparam int SEL_REG    = 0;
  localparam int SEL_IRAM   = 1;
  localparam int SEL_BW     = 2;
  localparam int SEL_BMP    = 3;

  localparam logic [REG_AW-1:0] RA_HBANK = 9'h024;
  localparam logic [REG_AW-1:0] RA_CBANK = 9'h025;
  localparam logic [REG_AW-1:0] RA_HBWE  = 9'h026;
  localparam logic [REG_AW-1:0] RA_CBWE  = 9'h027;
  localparam logic [REG_AW-1:0] RA_PROT  = 9'h028;
  localparam logic [REG_AW-1:0] RA_HIRAM = 9'h029;
  localparam logic [REG_AW-1:0] RA_CIRAM = 9'h02A;

  typedef struct packed {
    logic [HBANK_W-1:0]  host_bank;
    logic [CBANK_W-1:0]  cop_bank;
    logic                cop_bitmap;
    logic                host_bw_we;
    logic                cop_bw_we;
    logic [PROT_W-1:0]   prot_n;
    logic [N_CHUNKS-1:0] host_iram_we;
    logic [N_CHUNKS-1:0] cop_iram_we;
  } cfg_t;
endpackage

// File: rtl/mdec_cfg_regs.sv
module mdec_cfg_regs
  import dual_bus_decoder_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  logic [N_CHUNKS-1:0] iram_q [2];
  logic [N_CHUNKS-1:0] iram_d [2];

  // per-side internal-RAM chunk enables
  for (genvar s = 0; s < 2; s++) begin : g_iram
    localparam logic [REG_AW-1:0] ADR = (s == 0) ? RA_HIRAM : RA_CIRAM;
    always_comb begin
      iram_d[s] = iram_q[s];
      if (we_i && idx_i == ADR) iram_d[s] = wdata_i[N_CHUNKS-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) iram_q[s] <= '0;
      else         iram_q[s] <= iram_d[s];
    end
  end

  logic [HBANK_W-1:0] host_bank_q;
  logic [CBANK_W-1:0] cop_bank_q;
  logic               cop_bitmap_q, host_bw_we_q, cop_bw_we_q;
  logic [PROT_W-1:0]  prot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_bank_q  <= '0;
      cop_bank_q   <= '0;
      cop_bitmap_q <= 1'b0;
      host_bw_we_q <= 1'b0;
      cop_bw_we_q  <= 1'b0;
      prot_q       <= '0;
    end else if (we_i) begin
      unique case (idx_i)
        RA_HBANK: host_bank_q <= wdata_i[HBANK_W-1:0];
        RA_CBANK: begin
          cop_bank_q   <= wdata_i[CBANK_W-1:0];
          cop_bitmap_q <= wdata_i[7];
        end
        RA_HBWE:  host_bw_we_q <= wdata_i[7];
        RA_CBWE:  cop_bw_we_q  <= wdata_i[7];
        RA_PROT:  prot_q       <= wdata_i[PROT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_o.host_bank    = host_bank_q;
    cfg_o.cop_bank     = cop_bank_q;
    cfg_o.cop_bitmap   = cop_bitmap_q;
    cfg_o.host_bw_we   = host_bw_we_q;
    cfg_o.cop_bw_we    = cop_bw_we_q;
    cfg_o.prot_n       = prot_q;
    cfg_o.host_iram_we = iram_q[0];
    cfg_o.cop_iram_we  = iram_q[1];
  end
endmodule

// File: rtl/mdec_region_decode.sv
module mdec_region_decode
  import dual_bus_decoder_pkg::*;
(
  input  logic              req_i,
  input  logic              side_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  cfg_t              cfg_i,
  output logic [N_SEL-1:0]  sel_o,
  output logic [DEV_AW-1:0] dev_addr_o
);
  logic [15:0] off;
  logic        low_half;
  logic [3:0]  bank_hi;

  assign off      = addr_i[15:0];
  assign low_half = ~addr_i[22];
  assign bank_hi  = addr_i[23:20];

  always_comb begin
    sel_o      = '0;
    dev_addr_o = '0;
    if (req_i) begin
      if (low_half) begin
        if (side_i && off[15:IRAM_AW] == '0) begin
          sel_o[SEL_IRAM] = 1'b1;
          dev_addr_o      = DEV_AW'(off[IRAM_AW-1:0]);
        end else if (off[15:REG_AW] == 7'b0010001) begin
          sel_o[SEL_REG] = 1'b1;
          dev_addr_o     = DEV_AW'(off[REG_AW-1:0]);
        end else if (off[15:IRAM_AW] == 5'b00110) begin
          sel_o[SEL_IRAM] = 1'b1;
          dev_addr_o      = DEV_AW'(off[IRAM_AW-1:0]);
        end else if (off[15:WIN_AW] == 3'b011) begin
          if (!side_i) begin
            sel_o[SEL_BW] = 1'b1;
            dev_addr_o    = DEV_AW'({cfg_i.host_bank, off[WIN_AW-1:0]});
          end else begin
            sel_o[cfg_i.cop_bitmap ? SEL_BMP : SEL_BW] = 1'b1;
            dev_addr_o = DEV_AW'({cfg_i.cop_bank, off[WIN_AW-1:0]});
          end
        end
      end else if (bank_hi == 4'h4) begin
        sel_o[SEL_BW] = 1'b1;
        dev_addr_o    = addr_i[DEV_AW-1:0];
      end else if (bank_hi == 4'h6 && side_i) begin
        sel_o[SEL_BMP] = 1'b1;
        dev_addr_o     = addr_i[DEV_AW-1:0];
      end
    end
  end
endmodule

// File: rtl/mdec_wr_guard.sv
module mdec_wr_guard
  import dual_bus_decoder_pkg::*;
(
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              side_i,
  input  logic [N_SEL-1:0]  sel_i,
  input  logic [DEV_AW-1:0] dev_addr_i,
  input  cfg_t              cfg_i,
  output logic              wr_ok_o
);
  logic [DEV_AW-1:0]   prot_lim;
  logic [N_CHUNKS-1:0] iram_we;
  logic                bw_en, above_prot, iram_ok;

  assign prot_lim   = {{(DEV_AW-PROT_W-CHUNK_AW){1'b0}}, cfg_i.prot_n, {CHUNK_AW{1'b0}}};
  assign above_prot = dev_addr_i >= prot_lim;
  assign bw_en      = side_i ? cfg_i.cop_bw_we : cfg_i.host_bw_we;
  assign iram_we    = side_i ? cfg_i.cop_iram_we : cfg_i.host_iram_we;
  assign iram_ok    = iram_we[dev_addr_i[IRAM_AW-1:CHUNK_AW]];

  always_comb begin
    wr_ok_o = 1'b0;
    if (req_i && wr_i) begin
      unique case (1'b1)
        sel_i[SEL_REG]:  wr_ok_o = 1'b1;
        sel_i[SEL_IRAM]: wr_ok_o = iram_ok;
        sel_i[SEL_BW]:   wr_ok_o = bw_en | above_prot;
        sel_i[SEL_BMP]:  wr_ok_o = side_i & cfg_i.cop_bw_we;
        default:         wr_ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dual_bus_decoder.sv
module dual_bus_decoder
  import dual_bus_decoder_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              side_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SEL-1:0]  sel_o,
  output logic [DEV_AW-1:0] dev_addr_o,
  output logic              wr_ok_o
);
  cfg_t cfg;
  logic reg_we;

  assign reg_we = req_i & wr_i & sel_o[SEL_REG];

  mdec_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .idx_i   (dev_addr_o[REG_AW-1:0]),
    .wdata_i (wdata_i),
    .cfg_o   (cfg)
  );

  mdec_region_decode u_dec (
    .req_i      (req_i),
    .side_i     (side_i),
    .addr_i     (addr_i),
    .cfg_i      (cfg),
    .sel_o      (sel_o),
    .dev_addr_o (dev_addr_o)
  );

  mdec_wr_guard u_guard (
    .req_i      (req_i),
    .wr_i       (wr_i),
    .side_i     (side_i),
    .sel_i      (sel_o),
    .dev_addr_i (dev_addr_o),
    .cfg_i      (cfg),
    .wr_ok_o    (wr_ok_o)
  );
endmodule

// File: rtl/dual_bus_decoder_chk.sv
module dual_bus_decoder_chk
  import dual_bus_decoder_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              side_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SEL-1:0]  sel_o,
  input logic [DEV_AW-1:0] dev_addr_o,
  input logic              wr_ok_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0 && !wr_ok_o)); // R1

  AST_NO_SEL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |-> !wr_ok_o); // R1

  AST_ROM_BANKS_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[23:20] == 4'hC) |-> sel_o == '0); // R6

  AST_HOST_NO_BITMAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !side_i) |-> !sel_o[SEL_BMP]); // R7

  AST_REG_WRITE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && sel_o[SEL_REG]) |-> wr_ok_o); // R11

  AST_IRAM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && sel_o[SEL_REG] && dev_addr_o[REG_AW-1:0] == RA_HIRAM && wdata_i == '0)
    |=> !(req_i && wr_i && !side_i && sel_o[SEL_IRAM] && wr_ok_o)); // R10
endmodule

bind dual_bus_decoder dual_bus_decoder_chk chk_i (.*);

// File: tb/dual_bus_decoder_tb_top.sv
module dual_bus_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, side_i = 1'b0, wr_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [3:0]  sel_o;
  logic [19:0] dev_addr_o;
  logic        wr_ok_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_bus_decoder dut_i (.*);

  task automatic chk(input string tag, input logic [3:0] es, input logic [19:0] ea, input logic ew);
    total++;
    if (sel_o !== es || dev_addr_o !== ea || wr_ok_o !== ew) begin
      fails++;
      $display("FAIL %s: sel=%h addr=%h wok=%b expected sel=%h addr=%h wok=%b",
               tag, sel_o, dev_addr_o, wr_ok_o, es, ea, ew);
    end
  endtask

  task automatic acc(input logic s, input logic w, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; side_i = s; wr_i = w; addr_i = a; wdata_i = d;
    #4;
  endtask

  task automatic regw(input logic s, input logic [8:0] ra, input logic [7:0] d);
    acc(s, 1'b1, 24'h002200 | {15'h0, ra}, d);
    chk("R11 reg write", 4'h1, {11'h0, ra}, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 idle", 4'h0, 20'h0, 1'b0);
    acc(0, 1, 24'h003000, 8'h00); chk("R12 iram locked", 4'h2, 20'h0, 1'b0);
    acc(1, 1, 24'h600000, 8'h00); chk("R12 bitmap locked", 4'h8, 20'h0, 1'b0);
    acc(0, 0, 24'h006000, 8'h00); chk("R12 window bank0", 4'h4, 20'h0, 1'b0);
  endtask

  task automatic t_regs;
    acc(0, 0, 24'h002210, 0); chk("R2 reg", 4'h1, 20'h010, 1'b0);
    acc(1, 0, 24'h8023FF, 0); chk("R2 reg hi bank", 4'h1, 20'h1FF, 1'b0);
    acc(0, 0, 24'h002400, 0); chk("R2 past window", 4'h0, 20'h0, 1'b0);
    acc(0, 1, 24'h00221F, 8'hAA); chk("R11 unused offset", 4'h1, 20'h01F, 1'b1);
    acc(0, 0, 24'h006000, 0); chk("R11 unused no effect", 4'h4, 20'h0, 1'b0);
  endtask

  task automatic t_iram_map;
    acc(0, 0, 24'h003456, 0); chk("R3 host iram", 4'h2, 20'h456, 1'b0);
    acc(1, 0, 24'h000123, 0); chk("R3 cop low iram", 4'h2, 20'h123, 1'b0);
    acc(0, 0, 24'h000123, 0); chk("R3 host low none", 4'h0, 20'h0, 1'b0);
  endtask

  task automatic t_windows;
    regw(0, 9'h024, 8'h1F);
    acc(0, 0, 24'h006005, 0); chk("R4 host bank31", 4'h4, 20'h3E005, 1'b0);
    regw(0, 9'h024, 8'hE3);
    acc(0, 0, 24'h006005, 0); chk("R4 host bank masked", 4'h4, 20'h06005, 1'b0);
    regw(1, 9'h025, 8'h85);
    acc(1, 0, 24'h007001, 0); chk("R5 cop bitmap window", 4'h8, 20'h0B001, 1'b0);
    regw(1, 9'h025, 8'h05);
    acc(1, 0, 24'h007001, 0); chk("R5 cop normal window", 4'h4, 20'h0B001, 1'b0);
  endtask

  task automatic t_far_banks;
    acc(1, 0, 24'h412345, 0); chk("R6 cop linear", 4'h4, 20'h12345, 1'b0);
    acc(0, 0, 24'h4FFFFF, 0); chk("R6 host linear", 4'h4, 20'hFFFFF, 1'b0);
    acc(0, 0, 24'h402200, 0); chk("R6 bank40 not regs", 4'h4, 20'h02200, 1'b0);
    acc(0, 0, 24'hC12345, 0); chk("R6 C0 bank unmapped", 4'h0, 20'h0, 1'b0);
    acc(1, 0, 24'h512345, 0); chk("R6 bank50 unmapped", 4'h0, 20'h0, 1'b0);
    acc(1, 0, 24'h6ABCDE, 0); chk("R7 cop bitmap", 4'h8, 20'hABCDE, 1'b0);
    acc(0, 0, 24'h6ABCDE, 0); chk("R7 host no bitmap", 4'h0, 20'h0, 1'b0);
  endtask

  task automatic t_bw_protect;
    regw(1, 9'h028, 8'hF4);
    acc(0, 1, 24'h400010, 0); chk("R9 protected blocked", 4'h4, 20'h00010, 1'b0);
    acc(0, 1, 24'h4003FF, 0); chk("R9 last protected", 4'h4, 20'h003FF, 1'b0);
    acc(0, 1, 24'h400400, 0); chk("R9 boundary free", 4'h4, 20'h00400, 1'b1);
    acc(0, 1, 24'h006010, 0); chk("R9 window above", 4'h4, 20'h06010, 1'b1);
    regw(0, 9'h026, 8'h80);
    acc(0, 1, 24'h400010, 0); chk("R8 host enabled", 4'h4, 20'h00010, 1'b1);
    acc(1, 1, 24'h400010, 0); chk("R8 cop not enabled", 4'h4, 20'h00010, 1'b0);
    regw(0, 9'h026, 8'h7F);
    acc(0, 1, 24'h400010, 0); chk("R8 only bit7", 4'h4, 20'h00010, 1'b0);
    regw(1, 9'h027, 8'h80);
    acc(1, 1, 24'h600000, 0); chk("R8 bitmap enabled", 4'h8, 20'h0, 1'b1);
    acc(1, 1, 24'h400010, 0); chk("R8 cop enabled", 4'h4, 20'h00010, 1'b1);
  endtask

  task automatic t_iram_protect;
    regw(0, 9'h029, 8'h04);
    acc(0, 1, 24'h003200, 0); chk("R10 host chunk2", 4'h2, 20'h200, 1'b1);
    acc(0, 1, 24'h003300, 0); chk("R10 host chunk3", 4'h2, 20'h300, 1'b0);
    acc(1, 1, 24'h003200, 0); chk("R10 cop chunk2", 4'h2, 20'h200, 1'b0);
    regw(0, 9'h02A, 8'h80);
    acc(1, 1, 24'h000700, 0); chk("R10 cop chunk7", 4'h2, 20'h700, 1'b1);
    acc(0, 1, 24'h003700, 0); chk("R10 host chunk7", 4'h2, 20'h700, 1'b0);
    regw(1, 9'h029, 8'h00);
    acc(0, 1, 24'h003200, 0); chk("R10 host relocked", 4'h2, 20'h200, 1'b0);
  endtask

  initial begin
    #25;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    t_reset();
    t_regs();
    t_iram_map();
    t_windows();
    t_far_banks();
    t_bw_protect();
    t_iram_protect();
    @(negedge clk_i);
    req_i = 1'b0; wr_i = 1'b0;
    #4;
    chk("R1 idle end", 4'h0, 20'h0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule